// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block produces a single active-low reset request for a host processor. It merges three causes into that one output: the power-up condition, a supply fault reported as digital flags, and a watchdog that expires when software stops servicing it. All timing is counted in strobes of a 32.768 kHz tick that arrive as single-cycle enables on the system clock.

A two-bit configuration field picks one of three watchdog periods or switches the watchdog off. With the watchdog off, power-on and supply-fault reset still work. Software restarts the watchdog count by pulsing a service strobe or by writing the configuration field. Every reset, whatever its cause, stays asserted for a minimum pulse width counted in ticks. For a supply fault, that pulse width starts only after the fault clears.

Top module: `wd_reset_supervisor`

## Requirements
- R1: From synchronous reset onward `rst_n_out` is 0. It stays 0 until the supply is good, `pwr_good`=1 with `low_volt`=0, and the minimum pulse has then elapsed.
- R2: A supply fault is `pwr_good`=0 or `low_volt`=1. A fault present at a clock edge drives `rst_n_out` to 0 after that edge, and the output stays 0 for as long as the fault lasts, whatever the ticks do.
- R3: Once the fault clears, `rst_n_out` stays 0 for exactly PULSE_TICKS ticks and goes to 1 on the edge that takes the last of them.
- R4: With `cfg_sel`=2'b00 the watchdog limit is SHORT_TICKS (default 8192). The SHORT_TICKS-th tick after the last restart, if no service comes first, drives `rst_n_out` to 0; one tick fewer leaves it at 1.
- R5: With `cfg_sel`=2'b01 the limit is MID_TICKS (default 24576), with the same boundary rule as R4.
- R6: With `cfg_sel`=2'b10 the limit is LONG_TICKS (default 57344), with the same boundary rule as R4.
- R7: With `cfg_sel`=2'b11 the watchdog never expires, however many ticks arrive.
- R8: A `wd_kick` pulse restarts the watchdog count from zero.
- R9: A `cfg_wr` pulse latches `cfg_sel` and restarts the watchdog count from zero. The field resets to 2'b00.
- R10: A watchdog expiry holds `rst_n_out` at 0 for exactly PULSE_TICKS ticks. The watchdog then counts again from zero.
- R11: A supply fault during a watchdog reset pulse takes priority. The full PULSE_TICKS pulse restarts only after the fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz period |
| pwr_good | input | 1 | Supply present flag |
| low_volt | input | 1 | Low-voltage comparator flag |
| wd_kick | input | 1 | Watchdog service strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Watchdog period select: 00 short, 01 mid, 10 long, 11 off |
| rst_n_out | output | 1 | Active-low reset request |

## Verification
Each period setting is driven with exactly one tick fewer than its limit and with exactly the limit. This separates a correct compare from one that is off by one or that maps a setting to the wrong period. The off setting receives several times the longest period in ticks to show that it never expires. Service and configuration writes land just before expiry, and the bench then counts a full fresh period, so a restart that does not fully clear the count shows up. Each supply flag is raised on its own, and one is raised in the middle of a watchdog pulse, so the pulse length measured after the fault clears shows whether the fault took priority.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    typedef enum logic [1:0] {
        SUP_FAULT = 2'b00,
        SUP_HOLD  = 2'b01,
        SUP_RUN   = 2'b10
    } sup_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned wd_limit(input wd_sel_e s,
                                             input int unsigned t_short,
                                             input int unsigned t_mid,
                                             input int unsigned t_long);
        case (s)
            WD_SHORT: return t_short;
            WD_MID:   return t_mid;
            WD_LONG:  return t_long;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/wdsup_tick_counter.sv
module wdsup_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = inc && !clr && (cnt_q == limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            if (expire) cnt_q <= '0;
            else        cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/wd_reset_supervisor.sv
module wd_reset_supervisor
    import wdsup_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 8192,
    parameter int unsigned MID_TICKS   = 24576,
    parameter int unsigned LONG_TICKS  = 57344,
    parameter int unsigned PULSE_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       pwr_good,
    input  logic       low_volt,
    input  logic       wd_kick,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    output logic       rst_n_out
);
    localparam int unsigned MAX_T = max_u(max_u(SHORT_TICKS, MID_TICKS),
                                          max_u(LONG_TICKS, PULSE_TICKS));
    localparam int CW = $clog2(MAX_T + 1);

    sup_state_e state_q, state_d;
    wd_sel_e    sel_q;
    logic       fault;
    logic       wd_clr, wd_inc, wd_expire;
    logic       hold_clr, hold_inc, hold_done;
    logic [CW-1:0] wd_lim;

    assign fault = !pwr_good || low_volt;

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= WD_SHORT;
        else if (cfg_wr) sel_q <= wd_sel_e'(cfg_sel);
    end

    assign wd_lim = CW'(wd_limit(sel_q, SHORT_TICKS, MID_TICKS, LONG_TICKS));
    assign wd_clr = (state_q != SUP_RUN) || wd_kick || cfg_wr || (sel_q == WD_OFF);
    assign wd_inc = tick_en && (state_q == SUP_RUN);

    wdsup_tick_counter #(.W(CW)) i_wd_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (wd_clr),
        .inc    (wd_inc),
        .limit  (wd_lim),
        .expire (wd_expire)
    );

    assign hold_clr = (state_q != SUP_HOLD) || fault;
    assign hold_inc = tick_en && (state_q == SUP_HOLD);

    wdsup_tick_counter #(.W(CW)) i_hold_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold_clr),
        .inc    (hold_inc),
        .limit  (CW'(PULSE_TICKS)),
        .expire (hold_done)
    );

    always_comb begin
        state_d = state_q;
        if (fault) begin
            state_d = SUP_FAULT;
        end else begin
            case (state_q)
                SUP_FAULT: state_d = SUP_HOLD;
                SUP_HOLD:  if (hold_done) state_d = SUP_RUN;
                SUP_RUN:   if (wd_expire) state_d = SUP_HOLD;
                default:   state_d = SUP_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SUP_FAULT;
        else     state_q <= state_d;
    end

    assign rst_n_out = (state_q == SUP_RUN);
endmodule

// File: rtl/wdsup_checker.sv
module wdsup_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       pwr_good,
    input logic       low_volt,
    input logic       wd_kick,
    input logic [1:0] sel_q,
    input logic       rst_n_out
);
    logic fault;
    assign fault = !pwr_good || low_volt;

    AST_FAULT_RESETS: assert property (@(posedge clk) disable iff (rst)
        fault |=> !rst_n_out); // R2

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> ($past(tick_en) && !$past(fault))); // R3

    AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n_out) |-> ($past(fault) || $past(tick_en))); // R4

    AST_OFF_NEVER_EXPIRES: assert property (@(posedge clk) disable iff (rst)
        (rst_n_out && sel_q == 2'b11 && !fault) |=> rst_n_out); // R7

    AST_KICK_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (rst_n_out && wd_kick && !fault) |=> rst_n_out); // R8
endmodule

bind wd_reset_supervisor wdsup_checker i_wdsup_checker (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .pwr_good  (pwr_good),
    .low_volt  (low_volt),
    .wd_kick   (wd_kick),
    .sel_q     (sel_q),
    .rst_n_out (rst_n_out)
);

// File: tb/test_wd_reset_supervisor.sv
module test_wd_reset_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int T_SHORT = 8;
    localparam int T_MID   = 24;
    localparam int T_LONG  = 56;
    localparam int T_PULSE = 4;

    typedef struct packed {
        logic [1:0] sel;
        int         n;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'b00, T_SHORT - 1, 1'b1},   // R4
        '{2'b00, T_SHORT,     1'b0},   // R4
        '{2'b01, T_MID - 1,   1'b1},   // R5
        '{2'b01, T_MID,       1'b0},   // R5
        '{2'b10, T_LONG - 1,  1'b1},   // R6
        '{2'b10, T_LONG,      1'b0},   // R6
        '{2'b11, 4 * T_LONG,  1'b1}    // R7
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b0;
    logic pwr_good = 1'b0;
    logic low_volt = 1'b0;
    logic wd_kick = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic rst_n_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wd_reset_supervisor #(
        .SHORT_TICKS (T_SHORT),
        .MID_TICKS   (T_MID),
        .LONG_TICKS  (T_LONG),
        .PULSE_TICKS (T_PULSE)
    ) i_wd_reset_supervisor (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .pwr_good  (pwr_good),
        .low_volt  (low_volt),
        .wd_kick   (wd_kick),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .rst_n_out (rst_n_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rst_n_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic write_cfg(input logic [1:0] s);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_sel = s; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk) wd_kick = 1'b1;
        @(negedge clk) wd_kick = 1'b0;
    endtask

    task automatic recover(input string req);
        ticks(T_PULSE - 1);
        check(req, rst_n_out, 1'b0);
        ticks(1);
        check(req, rst_n_out, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, rst_n_out=%b expected=done", rst_n_out);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", rst_n_out, 1'b0);
        rst = 1'b0;
        ticks(2 * T_PULSE);
        check("R1 supply not good", rst_n_out, 1'b0);
        pwr_good = 1'b1;
        @(negedge clk);
        check("R1 pulse start", rst_n_out, 1'b0);
        recover("R1 R3 power-up pulse");

        // Table of period settings
        for (int v = 0; v < 7; v++) begin
            write_cfg(VECS[v].sel);
            ticks(VECS[v].n);
            check($sformatf("R4-6 vector %0d", v), rst_n_out, VECS[v].exp);
            if (!VECS[v].exp) recover("R10 watchdog pulse");
        end

        // R8: service restarts count
        write_cfg(2'b00);
        ticks(T_SHORT - 2);
        kick();
        ticks(T_SHORT - 1);
        check("R8 kick restart", rst_n_out, 1'b1);
        ticks(1);
        check("R8 expiry after kick", rst_n_out, 1'b0);
        recover("R10 after R8");

        // R9: configuration write restarts count
        ticks(T_SHORT - 2);
        write_cfg(2'b00);
        ticks(T_SHORT - 1);
        check("R9 cfg restart", rst_n_out, 1'b1);
        ticks(1);
        check("R9 expiry after cfg", rst_n_out, 1'b0);
        recover("R10 after R9");

        // R2/R3 low voltage
        @(negedge clk) low_volt = 1'b1;
        @(negedge clk);
        check("R2 low_volt asserts", rst_n_out, 1'b0);
        ticks(3 * T_PULSE);
        check("R2 held during fault", rst_n_out, 1'b0);
        @(negedge clk) low_volt = 1'b0;
        @(negedge clk);
        recover("R3 after low_volt");

        // R2 power-good loss
        @(negedge clk) pwr_good = 1'b0;
        @(negedge clk);
        check("R2 pwr_good loss", rst_n_out, 1'b0);
        @(negedge clk) pwr_good = 1'b1;
        @(negedge clk);
        recover("R3 after pwr_good");

        // R11: fault during a watchdog pulse
        ticks(T_SHORT);
        check("R11 wd expired", rst_n_out, 1'b0);
        ticks(T_PULSE - 2);
        @(negedge clk) low_volt = 1'b1;
        ticks(T_PULSE);
        check("R11 fault overrides", rst_n_out, 1'b0);
        @(negedge clk) low_volt = 1'b0;
        @(negedge clk);
        recover("R11 full pulse after fault");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule